// File: doc/BRIEF.md
# Machine Check Enable and Routing

This block decides, on every clock, what happens to a hardware error report. Four error sources arrive as single-cycle strobes: an external machine-check pin, cache parity, address bus parity and data bus parity. Each source has its own enable bit in a 32-bit control register. An error whose enable is set becomes an event. A machine-state enable input then picks the outcome: a one-cycle machine check exception, or a checkstop that holds until the next hard reset.

The same register carries three more things. It has a sticky flag that only a hard reset clears, so software can tell whether a hard reset has happened. It has separate enables for the instruction cache and the data cache. It has a bit that stops the bus interface from driving the snoop response lines back to their negated level. The register is written through a plain special-register write port and read back combinationally. The register uses big-endian bit numbering, so bit n of the register is vector index 31-n.

Top module: `mchk_unit`

## Requirements
- R1: While `hard_rst_n` is low, and on the first cycle after it rises, the register reads 0. In that state `mchk_exc` and `checkstop` are 0, `mchk_cause` is 0, and both cache-inhibit outputs are 1.
- R2: Only bits 0-3, 7, 15, 16 and 17 are implemented, which gives the read mask 0xF101C000. All other bits read 0 and ignore writes.
- R3: Each error source is gated by its own enable bit. Source index i (`err_strobe[i]`) is gated by register bit i: 0 for the external pin, 1 for cache parity, 2 for address parity and 3 for data parity. An error whose enable is clear has no effect on any output.
- R4: An enabled, unmasked error seen while `me_in` is 1 raises `mchk_exc` for exactly the cycle after the strobe cycle, and `checkstop` stays 0.
- R5: An enabled error seen while `me_in` is 0 sets `checkstop` in the next cycle. `checkstop` stays set until hard reset. While it is set, no `mchk_exc` pulse occurs and `mchk_cause` does not change.
- R6: Enabled errors in the same cycle produce a single event. `mchk_cause` holds the set of sources that fired, in the same bit order as `err_strobe`, and keeps that value until the next event or reset.
- R7: A register write takes effect in the cycle after it is accepted. An error in the same cycle as the write is judged against the old enable bits.
- R8: Bit 15 (mask 0x00010000) is set by writing 1 to it. Writing 0 does not clear it, and a soft reset does not clear it. Only a hard reset clears it.
- R9: `soft_rst` clears every register bit except bit 15 and clears `mchk_cause`. It takes priority over a write in the same cycle, suppresses any event in that cycle, and leaves `checkstop` unchanged.
- R10: `icache_inhibit` is the inverse of bit 16, `dcache_inhibit` is the inverse of bit 17, and `snoop_no_restore` equals bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_n | input | 1 | Synchronous hard reset, active low |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| spr_wr_en | input | 1 | Register write strobe |
| spr_wdata | input | 32 | Register write data |
| spr_rdata | output | 32 | Register read data |
| me_in | input | 1 | Machine-state enable: 1 takes an exception, 0 checkstops |
| err_strobe | input | 4 | Error pulses: [0] pin, [1] cache, [2] address, [3] data |
| mchk_exc | output | 1 | One-cycle machine check exception pulse |
| checkstop | output | 1 | Sticky checkstop |
| mchk_cause | output | 4 | Sources of the last event |
| icache_inhibit | output | 1 | Instruction cache treated as inhibited |
| dcache_inhibit | output | 1 | Data cache treated as inhibited |
| snoop_no_restore | output | 1 | Do not actively restore the snoop response lines |

## Verification
Single strobes are driven with only some enables set, to separate the gating of each source from the others. All four strobes are driven in one cycle, to separate one merged event from several. Strobes that coincide with a register write or a soft reset show whether the old or the new enables apply. Long random runs mix `me_in` values and occasional resets, so that the exception path, the checkstop path and the stickiness of the flag and of the checkstop are all compared cycle by cycle against a behavioural model.

// File: rtl/mchk_pkg.sv
package mchk_pkg;
  localparam int REG_W   = 32;
  localparam int NUM_SRC = 4;

  // big-endian bit positions within the control register
  localparam int POS_SRC0      = 0;   // sources use positions 0..NUM_SRC-1
  localparam int POS_SNP_HOLD  = 7;
  localparam int POS_NHR       = 15;
  localparam int POS_IC_EN     = 16;
  localparam int POS_DC_EN     = 17;

  function automatic int be_idx(input int pos);
    return REG_W - 1 - pos;
  endfunction

  function automatic logic [REG_W-1:0] be_bit(input int pos);
    logic [REG_W-1:0] v;
    v = '0;
    v[be_idx(pos)] = 1'b1;
    return v;
  endfunction

  function automatic logic [REG_W-1:0] impl_mask();
    logic [REG_W-1:0] m;
    m = be_bit(POS_SNP_HOLD) | be_bit(POS_NHR) | be_bit(POS_IC_EN) | be_bit(POS_DC_EN);
    for (int i = 0; i < NUM_SRC; i++) m |= be_bit(POS_SRC0 + i);
    return m;
  endfunction

  // sticky flag survives every write; others take masked write data
  function automatic logic [REG_W-1:0] next_cfg(input logic [REG_W-1:0] cur,
                                                input logic [REG_W-1:0] wdata);
    return (wdata & impl_mask()) | (cur & be_bit(POS_NHR));
  endfunction

  function automatic logic [NUM_SRC-1:0] gate_src(input logic [NUM_SRC-1:0] en,
                                                  input logic [NUM_SRC-1:0] strobe);
    return en & strobe;
  endfunction
endpackage

// File: rtl/mchk_cfg_reg.sv
module mchk_cfg_reg
  import mchk_pkg::*;
(
  input  logic               clk,
  input  logic               hard_rst_n,
  input  logic               soft_rst,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   cfg_q,
  output logic [NUM_SRC-1:0] src_en,
  output logic               snoop_hold,
  output logic               ic_en,
  output logic               dc_en
);
  localparam int IDX_NHR  = be_idx(POS_NHR);
  localparam int IDX_SNP  = be_idx(POS_SNP_HOLD);
  localparam int IDX_IC   = be_idx(POS_IC_EN);
  localparam int IDX_DC   = be_idx(POS_DC_EN);

  always_ff @(posedge clk) begin
    if (!hard_rst_n)
      cfg_q <= '0;
    else if (soft_rst)
      cfg_q <= cfg_q & be_bit(POS_NHR);
    else if (wr_en)
      cfg_q <= next_cfg(cfg_q, wdata);
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src_en
    localparam int IDX = be_idx(POS_SRC0 + i);
    assign src_en[i] = cfg_q[IDX];
  end

  assign snoop_hold = cfg_q[IDX_SNP];
  assign ic_en      = cfg_q[IDX_IC];
  assign dc_en      = cfg_q[IDX_DC];

  AST_NHR_STICKY: assert property (@(posedge clk) disable iff (!hard_rst_n)
    cfg_q[IDX_NHR] |=> cfg_q[IDX_NHR]); // R8

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (cfg_q & ~impl_mask()) == '0); // R2

  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!hard_rst_n)
    soft_rst |=> (src_en == '0) && !ic_en && !dc_en && !snoop_hold); // R9
endmodule

// File: rtl/mchk_route.sv
module mchk_route
  import mchk_pkg::*;
(
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [NUM_SRC-1:0] err_strobe,
  output logic [NUM_SRC-1:0] fired,
  output logic               any_fired
);
  assign fired     = gate_src(src_en, err_strobe);
  assign any_fired = |fired;
endmodule

// File: rtl/mchk_event.sv
module mchk_event
  import mchk_pkg::*;
(
  input  logic               clk,
  input  logic               hard_rst_n,
  input  logic               soft_rst,
  input  logic               me_in,
  input  logic [NUM_SRC-1:0] fired,
  input  logic               any_fired,
  output logic               exc_q,
  output logic               chk_q,
  output logic [NUM_SRC-1:0] cause_q
);
  logic take_evt;
  assign take_evt = any_fired && !chk_q && !soft_rst;

  always_ff @(posedge clk) begin
    if (!hard_rst_n) begin
      exc_q   <= 1'b0;
      chk_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      exc_q <= 1'b0;
      if (soft_rst) begin
        cause_q <= '0;
      end else if (take_evt) begin
        cause_q <= fired;
        if (me_in) exc_q <= 1'b1;
        else       chk_q <= 1'b1;
      end
    end
  end

  AST_CHKSTOP_STICKY: assert property (@(posedge clk) disable iff (!hard_rst_n)
    chk_q |=> chk_q); // R5

  AST_NO_EXC_IN_CHKSTOP: assert property (@(posedge clk) disable iff (!hard_rst_n)
    chk_q |-> !exc_q); // R5

  AST_EXC_NEEDS_ME: assert property (@(posedge clk) disable iff (!hard_rst_n)
    exc_q |-> $past(me_in)); // R4

  AST_EXC_HAS_CAUSE: assert property (@(posedge clk) disable iff (!hard_rst_n)
    exc_q |-> (cause_q != '0)); // R6

  AST_CAUSE_FROZEN: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (chk_q && !soft_rst) |=> $stable(cause_q)); // R5
endmodule

// File: rtl/mchk_unit.sv
module mchk_unit
  import mchk_pkg::*;
(
  input  logic               clk,
  input  logic               hard_rst_n,
  input  logic               soft_rst,
  input  logic               spr_wr_en,
  input  logic [REG_W-1:0]   spr_wdata,
  output logic [REG_W-1:0]   spr_rdata,
  input  logic               me_in,
  input  logic [NUM_SRC-1:0] err_strobe,
  output logic               mchk_exc,
  output logic               checkstop,
  output logic [NUM_SRC-1:0] mchk_cause,
  output logic               icache_inhibit,
  output logic               dcache_inhibit,
  output logic               snoop_no_restore
);
  logic [REG_W-1:0]   cfg_q;
  logic [NUM_SRC-1:0] src_en;
  logic [NUM_SRC-1:0] fired;
  logic               any_fired;
  logic               ic_en;
  logic               dc_en;
  logic               snoop_hold;

  mchk_cfg_reg u_cfg (
    .clk        (clk),
    .hard_rst_n (hard_rst_n),
    .soft_rst   (soft_rst),
    .wr_en      (spr_wr_en),
    .wdata      (spr_wdata),
    .cfg_q      (cfg_q),
    .src_en     (src_en),
    .snoop_hold (snoop_hold),
    .ic_en      (ic_en),
    .dc_en      (dc_en)
  );

  mchk_route u_route (
    .src_en     (src_en),
    .err_strobe (err_strobe),
    .fired      (fired),
    .any_fired  (any_fired)
  );

  mchk_event u_evt (
    .clk        (clk),
    .hard_rst_n (hard_rst_n),
    .soft_rst   (soft_rst),
    .me_in      (me_in),
    .fired      (fired),
    .any_fired  (any_fired),
    .exc_q      (mchk_exc),
    .chk_q      (checkstop),
    .cause_q    (mchk_cause)
  );

  assign spr_rdata        = cfg_q;
  assign icache_inhibit   = !ic_en;
  assign dcache_inhibit   = !dc_en;
  assign snoop_no_restore = snoop_hold;

  AST_GATED_NO_EVENT: assert property (@(posedge clk) disable iff (!hard_rst_n)
    (!any_fired && !checkstop) |=> !mchk_exc && !checkstop); // R3

  AST_CHK_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!hard_rst_n)
    $rose(checkstop) |-> $past(!me_in) && (mchk_cause != '0)); // R5
endmodule

// File: tb/test_mchk_unit.sv
module test_mchk_unit;
  logic        clk = 1'b0;
  logic        hard_rst_n, soft_rst, spr_wr_en, me_in;
  logic [31:0] spr_wdata;
  logic [3:0]  err_strobe;
  logic [31:0] spr_rdata;
  logic        mchk_exc, checkstop, icache_inhibit, dcache_inhibit, snoop_no_restore;
  logic [3:0]  mchk_cause;

  always #4 clk = ~clk;

  mchk_unit i_mchk_unit (
    .clk(clk), .hard_rst_n(hard_rst_n), .soft_rst(soft_rst),
    .spr_wr_en(spr_wr_en), .spr_wdata(spr_wdata), .spr_rdata(spr_rdata),
    .me_in(me_in), .err_strobe(err_strobe), .mchk_exc(mchk_exc),
    .checkstop(checkstop), .mchk_cause(mchk_cause),
    .icache_inhibit(icache_inhibit), .dcache_inhibit(dcache_inhibit),
    .snoop_no_restore(snoop_no_restore)
  );

  localparam logic [31:0] MASK = 32'hF101C000;
  localparam logic [31:0] FLAG = 32'h00010000;

  int n_chk = 0, n_bad = 0;
  logic [31:0] m_reg = '0;
  logic        m_exc = 0, m_chk = 0;
  logic [3:0]  m_cause = '0;

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    logic [31:0] nr;
    logic        ne, nc;
    logic [3:0]  nca, fired;
    nr = m_reg; ne = 0; nc = m_chk; nca = m_cause;
    if (!hard_rst_n) begin
      nr = '0; nc = 0; nca = '0;
    end else begin
      fired = '0;
      for (int i = 0; i < 4; i++) if (err_strobe[i] && m_reg[31-i]) fired[i] = 1'b1;
      if (soft_rst) begin
        nr = m_reg & FLAG; nca = '0;
      end else begin
        if (fired != 0 && !m_chk) begin
          nca = fired;
          if (me_in) ne = 1; else nc = 1;
        end
        if (spr_wr_en) nr = (spr_wdata & MASK) | (m_reg & FLAG);
      end
    end
    @(posedge clk);
    #2;
    m_reg = nr; m_exc = ne; m_chk = nc; m_cause = nca;
    cmp("R2 rdata", spr_rdata, m_reg);
    cmp("R4 exc", 32'(mchk_exc), 32'(m_exc));
    cmp("R5 checkstop", 32'(checkstop), 32'(m_chk));
    cmp("R6 cause", 32'(mchk_cause), 32'(m_cause));
    cmp("R10 icache_inhibit", 32'(icache_inhibit), 32'(!m_reg[15]));
    cmp("R10 dcache_inhibit", 32'(dcache_inhibit), 32'(!m_reg[14]));
    cmp("R10 snoop_no_restore", 32'(snoop_no_restore), 32'(m_reg[24]));
  endtask

  task automatic idle();
    spr_wr_en = 0; soft_rst = 0; err_strobe = '0; hard_rst_n = 1;
  endtask

  task automatic wr(input logic [31:0] d);
    idle(); spr_wr_en = 1; spr_wdata = d; step(); idle();
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    hard_rst_n = 0; soft_rst = 0; spr_wr_en = 0; spr_wdata = '0; me_in = 1; err_strobe = '0;
    step(); step();
    hard_rst_n = 1; step();
    cmp("R1 reset rdata", spr_rdata, 32'h0);
    cmp("R1 reset exc/chk", 32'({mchk_exc, checkstop}), 32'h0);
    cmp("R1 reset inhibits", 32'({icache_inhibit, dcache_inhibit}), 32'h3);

    wr(32'hFFFFFFFF);
    cmp("R2 implemented mask", spr_rdata, MASK);

    // R3: only cache parity enabled, pin strobe ignored
    wr(32'h40000000);
    err_strobe = 4'b0001; step(); idle();
    cmp("R3 pin gated off", 32'(mchk_exc), 32'h0);
    err_strobe = 4'b0010; step(); idle();
    cmp("R4 cache parity exc", 32'({mchk_exc, checkstop}), 32'h2);
    step();
    cmp("R4 exc single cycle", 32'(mchk_exc), 32'h0);

    // R7: write and strobe in same cycle use old enables
    spr_wr_en = 1; spr_wdata = 32'hF0000000; err_strobe = 4'b0001; step(); idle();
    cmp("R7 old enable applies", 32'(mchk_exc), 32'h0);
    err_strobe = 4'b0001; step(); idle();
    cmp("R7 new enable applies", 32'(mchk_exc), 32'h1);

    // R6: all sources in one cycle
    err_strobe = 4'b1111; step(); idle();
    cmp("R6 merged cause", 32'(mchk_cause), 32'hF);
    step();
    cmp("R6 one event only", 32'({mchk_exc, mchk_cause}), 32'h0F);

    // R8: writing 0 keeps flag
    wr(32'h0);
    cmp("R8 flag kept on write 0", spr_rdata, FLAG);

    // R9: soft reset wins over write, suppresses event, keeps flag
    wr(MASK);
    soft_rst = 1; spr_wr_en = 1; spr_wdata = MASK; err_strobe = 4'b0001; step(); idle();
    cmp("R9 soft reset state", spr_rdata, FLAG);
    cmp("R9 no event", 32'({mchk_exc, mchk_cause}), 32'h0);

    // R5: checkstop sticky, blocks later exceptions
    wr(32'hF0000000);
    me_in = 0; err_strobe = 4'b1000; step(); idle();
    cmp("R5 checkstop entered", 32'(checkstop), 32'h1);
    me_in = 1; err_strobe = 4'b0001; step(); idle();
    cmp("R5 no exc in checkstop", 32'({mchk_exc, mchk_cause}), 32'h08);
    soft_rst = 1; step(); idle();
    cmp("R5 soft keeps checkstop", 32'(checkstop), 32'h1);
    hard_rst_n = 0; step(); idle(); step();
    cmp("R1 hard reset clears", 32'({checkstop, spr_rdata[15:0], spr_rdata[31:16]}), 32'h0);

    for (int c = 0; c < 6000; c++) begin
      hard_rst_n = ($urandom_range(0, 299) != 0);
      soft_rst   = ($urandom_range(0, 99) == 0);
      spr_wr_en  = ($urandom_range(0, 9) == 0);
      spr_wdata  = $urandom();
      me_in      = ($urandom_range(0, 7) != 0);
      err_strobe = ($urandom_range(0, 2) == 0) ? 4'($urandom()) : 4'b0;
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule